// File: doc/BRIEF.md
# High-Speed NRZI Transmit Driver Controller

This block sits between a serial bit source and a current-steering differential line driver. The bit source offers one bit per cycle on a valid/ready stream. The block NRZI-encodes each accepted bit into a line level and drives three plain control pins:

- a current-source enable;
- a shunt enable, which dumps the current to ground and leaves both lines low (idle);
- a steering bit, which sends the current into D+ (J state) or D- (K state).

A packet is bracketed by a transmit-request level. Between packets the shunt is on. While bits flow the shunt is off, and the steering bit alone picks the line.

A power-mode input selects one of two schemes. In the economy scheme the current source stays off between packets. It then switches on a parameterised number of clocks before the first bit reaches the line, so the source can settle. In the standby scheme the current source is never switched off and only the shunt gates the line, so the first bit goes out with no warm-up. A status output reports every cycle whether the line is idle, J or K.

The stream follows valid/ready rules. A bit transfers on a cycle where both `bit_valid` and `bit_ready` are high. `bit_ready` is low during warm-up and between packets. A source that sees `bit_ready` low must hold its bit and valid until the bit is taken. A cycle inside a packet with `bit_valid` low is a gap: the shunt turns on for that cycle and the NRZI level is kept.

Top module: `hstx_drive_ctrl`

## Requirements
- R1: While reset is held and in the cycles after its release with the economy mode selected and no request, `cur_en`=0, `drv_en`=1, `tx_data`=0, `bit_ready`=0 and `line_state`=0 (idle).
- R2: Within a packet, an accepted 0 bit drives the opposite level to the previous bit on the line, and an accepted 1 bit repeats it.
- R3: The NRZI level restarts at J for every packet, so a first bit of 0 is sent as K and a first bit of 1 as J.
- R4: While `drv_en`=0, `tx_data`=1 steers current into D+ (J) and `tx_data`=0 into D- (K); `line_state` reports 1 for J and 2 for K.
- R5: Whenever `drv_en`=1, `tx_data`=0 and `line_state`=0 (idle).
- R6: In economy mode (`always_on`=0), `cur_en` is 0 between packets and rises one cycle after `tx_req` is first sampled high. With a bit held valid, `drv_en` first falls exactly SETTLE_CLKS cycles after `cur_en` rises (default 2).
- R7: In standby mode (`always_on`=1), `cur_en` stays 1 between packets. With a bit held valid, `drv_en` first falls two cycles after `tx_req` is first sampled high.
- R8: `bit_ready` is 0 during warm-up and while idle. A bit offered before `bit_ready` is held and is sent as the first bit once accepted.
- R9: `drv_en` returns to 1 in the cycle after the last accepted bit. In economy mode, `cur_en` falls in that same cycle when `tx_req` and `bit_valid` were low.
- R10: `drv_en` is never 0 while `cur_en` is 0.
- R11: A cycle inside a packet with `bit_valid`=0 gives `drv_en`=1 for one cycle, and the NRZI level carries across the gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_req | input | 1 | High for the duration of a packet |
| always_on | input | 1 | 1 = standby scheme (current always on), 0 = economy scheme |
| bit_valid | input | 1 | A bit is offered on `bit_data` |
| bit_data | input | 1 | Bit to send (before NRZI) |
| bit_ready | output | 1 | Block can take a bit this cycle |
| cur_en | output | 1 | Current-source enable |
| drv_en | output | 1 | Shunt current to ground (line idle) |
| tx_data | output | 1 | Steering: 1 = D+ (J), 0 = D- (K) |
| line_state | output | 2 | 0 idle, 1 J, 2 K |

## Verification
The bench sends all 256 eight-bit patterns in both power modes and predicts each line level by toggling a J-seeded level for every 0. It checks the following cases:

- **Level carried between packets.** A design that keeps the level from the previous packet fails on the first bit of half the patterns.
- **Warm-up length.** The bench counts the cycles from current enable to the first bit on the line. An off-by-one warm-up counter shows up here, as does a standby mode that still waits.
- **Consumed waiting bit.** A design that takes the held bit during warm-up corrupts the first level.
- **Mid-packet gap.** One pass inserts a gap. A design that reseeds the level or keeps driving during the gap gives wrong levels after it.
- **Packet end.** The last bit must be followed by one cycle with the shunt on and, in economy mode, the current off. A design that lingers or cuts early breaks the tail checks.

// File: rtl/hstx_pkg.sv
package hstx_pkg;

  typedef enum logic [1:0] {
    LS_IDLE = 2'd0,
    LS_J    = 2'd1,
    LS_K    = 2'd2
  } line_st_t;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_WARM = 2'd1,
    SQ_SEND = 2'd2
  } seq_st_t;

endpackage

// File: rtl/hstx_seq.sv
module hstx_seq
  import hstx_pkg::*;
#(
  parameter int SETTLE_CLKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_req,
  input  logic always_on,
  input  logic bit_valid,
  output logic bit_ready,
  output logic accept,
  output logic sending,
  output logic cur_en
);

  localparam int CW = (SETTLE_CLKS > 2) ? $clog2(SETTLE_CLKS) : 1;
  localparam logic [CW-1:0] WARM_LOAD = CW'((SETTLE_CLKS > 1) ? SETTLE_CLKS - 2 : 0);
  localparam bit SKIP_WARM = (SETTLE_CLKS <= 1);

  seq_st_t st_q, st_nxt;
  logic [CW-1:0] cnt_q, cnt_nxt;
  logic cur_q;

  assign sending   = (st_q == SQ_SEND);
  assign bit_ready = sending;
  assign accept    = sending && bit_valid;
  assign cur_en    = cur_q;

  always_comb begin
    st_nxt  = st_q;
    cnt_nxt = cnt_q;
    unique case (st_q)
      SQ_IDLE: begin
        if (tx_req) begin
          if (always_on || SKIP_WARM) begin
            st_nxt = SQ_SEND;
          end else begin
            st_nxt  = SQ_WARM;
            cnt_nxt = WARM_LOAD;
          end
        end
      end
      SQ_WARM: begin
        if (!tx_req) begin
          st_nxt = SQ_IDLE;
        end else if (cnt_q == '0) begin
          st_nxt = SQ_SEND;
        end else begin
          cnt_nxt = cnt_q - 1'b1;
        end
      end
      SQ_SEND: begin
        if (!accept && !tx_req) st_nxt = SQ_IDLE;
      end
      default: st_nxt = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      cnt_q <= '0;
      cur_q <= 1'b0;
    end else begin
      st_q  <= st_nxt;
      cnt_q <= cnt_nxt;
      cur_q <= always_on || (st_nxt != SQ_IDLE);
    end
  end

  AST_WARM_HAS_CURRENT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_WARM) |=> cur_en); // R6

  AST_WARM_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_WARM && !always_on) |-> !bit_ready); // R8

endmodule

// File: rtl/hstx_nrzi.sv
module hstx_nrzi (
  input  logic clk,
  input  logic rst_n,
  input  logic sending,
  input  logic accept,
  input  logic bit_in,
  output logic tx_data,
  output logic drv_en
);

  logic lvl_q, lvl_nxt;
  logic txd_q, drv_q;

  assign lvl_nxt = bit_in ? lvl_q : ~lvl_q;
  assign tx_data = txd_q;
  assign drv_en  = drv_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q <= 1'b1;
      txd_q <= 1'b0;
      drv_q <= 1'b1;
    end else begin
      drv_q <= !accept;
      txd_q <= accept ? lvl_nxt : 1'b0;
      if (!sending)    lvl_q <= 1'b1;
      else if (accept) lvl_q <= lvl_nxt;
    end
  end

  AST_NRZI_ONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && bit_in && !drv_en) |=> (tx_data == $past(tx_data))); // R2

  AST_NRZI_ZERO_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !bit_in && !drv_en) |=> (tx_data != $past(tx_data))); // R2

endmodule

// File: rtl/hstx_linemon.sv
module hstx_linemon
  import hstx_pkg::*;
(
  input  logic       drv_en,
  input  logic       tx_data,
  output logic [1:0] line_state
);

  line_st_t ls;

  always_comb begin
    if (drv_en)       ls = LS_IDLE;
    else if (tx_data) ls = LS_J;
    else              ls = LS_K;
  end

  assign line_state = ls;

endmodule

// File: rtl/hstx_drive_ctrl.sv
module hstx_drive_ctrl
  import hstx_pkg::*;
#(
  parameter int SETTLE_CLKS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_req,
  input  logic       always_on,
  input  logic       bit_valid,
  input  logic       bit_data,
  output logic       bit_ready,
  output logic       cur_en,
  output logic       drv_en,
  output logic       tx_data,
  output logic [1:0] line_state
);

  logic accept;
  logic sending;

  hstx_seq #(.SETTLE_CLKS(SETTLE_CLKS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_req    (tx_req),
    .always_on (always_on),
    .bit_valid (bit_valid),
    .bit_ready (bit_ready),
    .accept    (accept),
    .sending   (sending),
    .cur_en    (cur_en)
  );

  hstx_nrzi u_nrzi (
    .clk     (clk),
    .rst_n   (rst_n),
    .sending (sending),
    .accept  (accept),
    .bit_in  (bit_data),
    .tx_data (tx_data),
    .drv_en  (drv_en)
  );

  hstx_linemon u_mon (
    .drv_en     (drv_en),
    .tx_data    (tx_data),
    .line_state (line_state)
  );

  AST_DRIVE_NEEDS_CURRENT: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_en |-> cur_en); // R10

  AST_READY_NEEDS_CURRENT: assert property (@(posedge clk) disable iff (!rst_n)
    bit_ready |-> cur_en); // R8

  AST_IDLE_STEER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (line_state == LS_IDLE) |-> !tx_data); // R5

  AST_BIT_ENDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_valid && !drv_en) |=> drv_en); // R9

endmodule

// File: tb/tb_hstx_drive_ctrl.sv
module tb_hstx_drive_ctrl;

  localparam int SETTLE = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_req = 1'b0;
  logic always_on = 1'b0;
  logic bit_valid = 1'b0;
  logic bit_data = 1'b0;
  logic bit_ready, cur_en, drv_en, tx_data;
  logic [1:0] line_state;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  hstx_drive_ctrl #(.SETTLE_CLKS(SETTLE)) dut (
    .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .always_on(always_on),
    .bit_valid(bit_valid), .bit_data(bit_data), .bit_ready(bit_ready),
    .cur_en(cur_en), .drv_en(drv_en), .tx_data(tx_data), .line_state(line_state)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_idle(input string req, input int cur_exp);
    chk(req, drv_en, 1);
    chk(req, tx_data, 0);
    chk(req, line_state, 0);
    chk(req, bit_ready, 0);
    chk(req, cur_en, cur_exp);
  endtask

  // One packet of n bits; optional one-cycle gap before bit index 3 (R11)
  task automatic run_pkt(input bit aon, input logic [7:0] pat, input int n, input bit gap);
    int idx = 0;
    int cyc = 0;
    int first_drv = -1;
    int first_cur = -1;
    bit lvl = 1'b1;
    bit acc;
    bit bitv;
    bit ending = 1'b0;
    bit gap_done = 1'b0;
    tx_req = 1'b1; bit_valid = 1'b1; bit_data = pat[0];
    acc = bit_valid && bit_ready;
    bitv = bit_data;
    while (cyc < 60) begin
      @(negedge clk);
      cyc++;
      if (cur_en && first_cur < 0) first_cur = cyc;
      if (cyc == 1 && !aon) chk("R8 no ready in warm-up", bit_ready, 0);
      if (acc) begin
        lvl = bitv ? lvl : ~lvl;   // R2 / R3: seeded at J per packet
        if (first_drv < 0) first_drv = cyc;
        chk("R2 R3 level", tx_data, lvl);
        chk("R4 line state", line_state, lvl ? 1 : 2);
        chk("R10 current on", cur_en, 1);
        idx++;
      end else begin
        chk(gap_done && idx == 3 && !ending ? "R11 gap idle" : "R5 R9 idle", drv_en, 1);
        chk("R5 steer low", tx_data, 0);
        chk("R5 line idle", line_state, 0);
      end
      if (ending) begin
        chk("R9 current after end", cur_en, aon ? 1 : 0);
        break;
      end
      if (gap && idx == 3 && !gap_done) begin
        bit_valid = 1'b0; gap_done = 1'b1;
      end else if (idx < n) begin
        bit_valid = 1'b1; bit_data = pat[idx];
      end else begin
        bit_valid = 1'b0; tx_req = 1'b0; ending = 1'b1;
      end
      acc = bit_valid && bit_ready;
      bitv = bit_data;
    end
    chk("R2 all bits sent", idx, n);
    if (aon) begin
      chk("R7 first bit timing", first_drv, 2);
    end else begin
      chk("R6 current rises", first_cur, 1);
      chk("R6 settle", first_drv - first_cur, SETTLE);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_idle("R1 in reset", 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_idle("R1 after reset", 0);
    for (int m = 0; m < 2; m++) begin
      always_on = (m == 1);
      repeat (3) @(negedge clk);
      chk_idle(m == 1 ? "R7 standby idle" : "R6 economy idle", m);
      for (int p = 0; p < 256; p++) begin
        run_pkt(m == 1, 8'(p), 8, 1'b0);
        @(negedge clk);
        chk_idle(m == 1 ? "R7 between packets" : "R6 between packets", m);
      end
      run_pkt(m == 1, 8'hA6, 8, 1'b1);
      run_pkt(m == 1, 8'h00, 8, 1'b1);
      @(negedge clk);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule